// File: doc/BRIEF.md
# Legacy Memory Hole Attribute Decoder

This block steers CPU memory accesses that fall in the legacy hole from 0xC0000 to 0xFFFFF. A bank of seven byte-wide attribute registers is written and read through a small configuration port. Each byte holds two 4-bit attribute fields, and each field controls one address window. Bit 0 of a field lets reads of the window go to DRAM. Bit 1 lets writes go to DRAM. An access that its window does not allow to DRAM is forwarded to the bus side, where ROM or devices answer.

Because the read and write permissions are separate, software can shadow a ROM into RAM. It first allows writes only, so that reads still reach the ROM while a copy of it is written into DRAM. It then allows reads as well, and the copy in DRAM becomes visible. Addresses outside the hole always go to DRAM. For every access the block returns a registered decision one cycle after the access is presented.

Top module: `legacy_hole_decoder`

## Requirements
- R1: After reset all seven attribute bytes read back as 0x00, so every access inside the hole is forwarded to the bus side.
- R2: A write to offset 0x59+k (k = 0..6) replaces the whole byte, including bits 2 and 3 of each field. A read of that offset returns the stored byte on cfg_rdata in the cycle after the read strobe.
- R3: Writes to offsets outside 0x59..0x5F change no attribute byte, and reads of such offsets return 0x00.
- R4: Window index i is controlled by byte 0x59 + i/2. Even indices use bits 3:0 and odd indices use bits 7:4. Within a field, bit 0 is read-enable and bit 1 is write-enable. Index 0 controls no window.
- R5: Index 1 covers 0xF0000..0xFFFFF. Indices 2..13 cover the 16 KB windows 0xC0000 + (i-2)*0x4000, up to 0xEFFFF.
- R6: A read inside a window goes to DRAM when that window's read-enable is set, and is forwarded to the bus otherwise.
- R7: A write inside a window goes to DRAM when that window's write-enable is set, and is forwarded to the bus otherwise.
- R8: Any access to an address below 0xC0000 or above 0xFFFFF goes to DRAM, whatever the attributes are.
- R9: Bits 2 and 3 of a field have no effect on steering.
- R10: An access presented in cycle n produces acc_valid and its decision in cycle n+1. A configuration write in cycle n affects accesses presented from cycle n+1 on. An access presented in the same cycle as the write is steered by the old value.
- R11: While acc_valid is high exactly one of dram_sel and bus_fwd is high. While acc_valid is low both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered configuration read data |
| mem_valid | input | 1 | CPU memory access present |
| mem_write | input | 1 | 1 = write access, 0 = read access |
| mem_addr | input | ADDR_W | CPU byte address |
| acc_valid | output | 1 | Decision valid for the access of the previous cycle |
| dram_sel | output | 1 | Access is served by DRAM |
| bus_fwd | output | 1 | Access is forwarded to the bus side |

## Verification
The hardest case to reach from the ports is a configuration write and a memory access to the window it changes, both landing on the same clock edge. Ordinary sequences always separate the two, so they never show whether the access sees the old value or the new one. A dedicated task drives both strobes on the same cycle and then repeats the access on the next cycle. The two results must differ. A second task walks the whole shadowing sequence on one window: write-only, then read-and-write, then cleared. In each step the read and the write to the same address must go to different targets or to the same target, as the fields dictate.

// File: rtl/lhd_pkg.sv
package lhd_pkg;
  // bit positions inside a 4-bit attribute field
  localparam int FLD_RD_BIT = 0;
  localparam int FLD_WR_BIT = 1;
  localparam int FLD_W      = 4;

  typedef struct packed {
    logic valid;
    logic dram;
    logic bus;
  } steer_t;
endpackage

// File: rtl/lhd_attr_bank.sv
module lhd_attr_bank #(
  parameter int          NUM_BYTES = 7,
  parameter int          OFF_W     = 8,
  parameter int unsigned BASE_OFF  = 32'h59
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic                   cfg_rd,
  input  logic [OFF_W-1:0]       cfg_off,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             cfg_rdata,
  output logic [NUM_BYTES*8-1:0] attr_flat
);
  logic [7:0] attr_q [NUM_BYTES];
  logic [7:0] rd_mux;

  genvar g;
  generate
    for (g = 0; g < NUM_BYTES; g++) begin : g_byte
      localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(BASE_OFF + g);
      always_ff @(posedge clk) begin
        if (rst)
          attr_q[g] <= 8'h00;
        else if (cfg_wr && (cfg_off == MY_OFF))
          attr_q[g] <= cfg_wdata;
      end
      assign attr_flat[g*8 +: 8] = attr_q[g];
    end
  endgenerate

  always_comb begin
    rd_mux = 8'h00;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (cfg_off == OFF_W'(BASE_OFF + k))
        rd_mux = attr_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= 8'h00;
    else if (cfg_rd)
      cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/lhd_region_lookup.sv
module lhd_region_lookup #(
  parameter int                ADDR_W    = 32,
  parameter int                NUM_REG   = 14,
  parameter longint unsigned   HOLE_LO   = 64'h000C_0000,
  parameter longint unsigned   TOP_BASE  = 64'h000F_0000,
  parameter longint unsigned   HOLE_HI   = 64'h000F_FFFF,
  parameter int                WIN_SHIFT = 14
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_REG-1:0] hit
);
  localparam longint unsigned WIN_SIZE = 64'd1 << WIN_SHIFT;

  // index 0 is reserved and never matches
  assign hit[0] = 1'b0;

  genvar g;
  generate
    for (g = 1; g < NUM_REG; g++) begin : g_win
      if (g == 1) begin : g_top
        assign hit[g] = (addr >= ADDR_W'(TOP_BASE)) && (addr <= ADDR_W'(HOLE_HI));
      end else begin : g_small
        localparam longint unsigned LO = HOLE_LO + longint'(g - 2) * WIN_SIZE;
        localparam longint unsigned HI = LO + WIN_SIZE - 64'd1;
        assign hit[g] = (addr >= ADDR_W'(LO)) && (addr <= ADDR_W'(HI));
      end
    end
  endgenerate
endmodule

// File: rtl/lhd_steer.sv
module lhd_steer
  import lhd_pkg::*;
#(
  parameter int NUM_BYTES = 7,
  localparam int NUM_REG  = 2 * NUM_BYTES
) (
  input  logic [NUM_BYTES*8-1:0] attr_flat,
  input  logic [NUM_REG-1:0]     hit,
  input  logic                   valid,
  input  logic                   is_write,
  output steer_t                 dec
);
  logic [NUM_REG-1:0]   rd_en;
  logic [NUM_REG-1:0]   wr_en;
  logic [NUM_REG*2-1:0] unused_spare;
  logic                 in_hole;
  logic                 allow;

  genvar g;
  generate
    for (g = 0; g < NUM_REG; g++) begin : g_fld
      localparam int LSB = (g / 2) * 8 + (g % 2) * FLD_W;
      assign rd_en[g]            = attr_flat[LSB + FLD_RD_BIT];
      assign wr_en[g]            = attr_flat[LSB + FLD_WR_BIT];
      assign unused_spare[g*2 +: 2] = attr_flat[LSB + 2 +: 2];
    end
  endgenerate

  assign in_hole = |hit;
  assign allow   = |(hit & (is_write ? wr_en : rd_en));

  always_comb begin
    dec.valid = valid;
    dec.dram  = valid && (!in_hole || allow);
    dec.bus   = valid && in_hole && !allow;
  end
endmodule

// File: rtl/legacy_hole_decoder.sv
module legacy_hole_decoder
  import lhd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_BYTES = 7,
  parameter int WIN_SHIFT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [7:0]        cfg_off,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              acc_valid,
  output logic              dram_sel,
  output logic              bus_fwd
);
  localparam int NUM_REG = 2 * NUM_BYTES;

  logic [NUM_BYTES*8-1:0] attr_flat;
  logic [NUM_REG-1:0]     hit;
  steer_t                 dec;

  lhd_attr_bank #(.NUM_BYTES(NUM_BYTES), .OFF_W(8), .BASE_OFF(32'h59)) u_bank (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .attr_flat(attr_flat)
  );

  lhd_region_lookup #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .WIN_SHIFT(WIN_SHIFT)) u_look (
    .addr(mem_addr), .hit(hit)
  );

  lhd_steer #(.NUM_BYTES(NUM_BYTES)) u_steer (
    .attr_flat(attr_flat), .hit(hit), .valid(mem_valid),
    .is_write(mem_write), .dec(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      dram_sel  <= 1'b0;
      bus_fwd   <= 1'b0;
    end else begin
      acc_valid <= dec.valid;
      dram_sel  <= dec.dram;
      bus_fwd   <= dec.bus;
    end
  end
endmodule

// File: rtl/lhd_checker.sv
module lhd_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_rd,
  input logic [7:0]        cfg_off,
  input logic [7:0]        cfg_rdata,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              acc_valid,
  input logic              dram_sel,
  input logic              bus_fwd
);
  logic outside;
  assign outside = (mem_addr < ADDR_W'(32'h000C_0000)) || (mem_addr > ADDR_W'(32'h000F_FFFF));

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cfg_rdata == 8'h00) && !acc_valid && !dram_sel && !bus_fwd);

  a_r3_foreign_read_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && ((cfg_off < 8'h59) || (cfg_off > 8'h5F))) |=> (cfg_rdata == 8'h00));

  a_r8_outside_dram: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && outside) |=> dram_sel);

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> acc_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !mem_valid |=> !acc_valid);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $countones({dram_sel, bus_fwd}) == 1);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !dram_sel && !bus_fwd);
endmodule

bind legacy_hole_decoder lhd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_off(cfg_off),
  .cfg_rdata(cfg_rdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .acc_valid(acc_valid), .dram_sel(dram_sel), .bus_fwd(bus_fwd)
);

// File: tb/legacy_hole_decoder_bench.sv
module legacy_hole_decoder_bench;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0] cfg_off = 8'h00, cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic mem_valid = 1'b0, mem_write = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic acc_valid, dram_sel, bus_fwd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  legacy_hole_decoder #(.ADDR_W(ADDR_W)) u_legacy_hole_decoder (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .acc_valid(acc_valid), .dram_sel(dram_sel), .bus_fwd(bus_fwd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input string req, input logic [7:0] off, input logic [7:0] exp);
    @(negedge clk); cfg_rd = 1'b1; cfg_off = off;
    @(negedge clk); cfg_rd = 1'b0;
    check(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  // exp_dram = 1: DRAM, 0: bus; also checks valid and exclusivity (R11)
  task automatic access(input string req, input logic wr, input logic [31:0] a, input logic exp_dram);
    @(negedge clk); mem_valid = 1'b1; mem_write = wr; mem_addr = a;
    @(negedge clk); mem_valid = 1'b0;
    check(req, {29'h0, acc_valid, dram_sel, bus_fwd}, {29'h0, 1'b1, exp_dram, !exp_dram});
  endtask

  task automatic clear_all();
    for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h00);
  endtask

  function automatic logic [31:0] win_lo(input int i);
    return (i == 1) ? 32'h000F_0000 : 32'h000C_0000 + 32'(i - 2) * 32'h4000;
  endfunction
  function automatic logic [31:0] win_hi(input int i);
    return (i == 1) ? 32'h000F_FFFF : win_lo(i) + 32'h3FFF;
  endfunction

  task automatic set_field(input int i, input logic [3:0] v);
    logic [7:0] b;
    b = (i % 2 == 1) ? {v, 4'h0} : {4'h0, v};
    cfg_write(8'(8'h59 + i / 2), b);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 7; k++) cfg_read("R1 reset byte", 8'(8'h59 + k), 8'h00);
    check("R11 idle after reset", {30'h0, dram_sel, bus_fwd}, 32'h0);
    access("R1 read hole after reset", 1'b0, 32'h000F_1234, 1'b0);
    access("R1 write hole after reset", 1'b1, 32'h000C_0000, 1'b0);
  endtask

  task automatic t_regs();
    for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'(8'hA5 ^ (k * 8'h11)));
    for (int k = 0; k < 7; k++) cfg_read("R2 readback", 8'(8'h59 + k), 8'(8'hA5 ^ (k * 8'h11)));
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_read("R3 foreign 0x58", 8'h58, 8'h00);
    cfg_read("R3 foreign 0x60", 8'h60, 8'h00);
    cfg_read("R3 neighbour 0x59 kept", 8'h59, 8'hA5);
    cfg_read("R3 neighbour 0x5F kept", 8'h5F, 8'(8'hA5 ^ 8'h66));
    clear_all();
  endtask

  task automatic t_map();
    for (int i = 1; i < 14; i++) begin
      clear_all();
      set_field(i, 4'h1);
      access("R4 R5 R6 read window low", 1'b0, win_lo(i), 1'b1);
      access("R4 R5 R6 read window high", 1'b0, win_hi(i), 1'b1);
      access("R7 write with WE clear", 1'b1, win_lo(i), 1'b0);
      if (i >= 3) access("R5 previous window untouched", 1'b0, win_hi(i - 1), 1'b0);
      if (i >= 2 && i < 13) access("R5 next window untouched", 1'b0, win_lo(i + 1), 1'b0);
    end
    clear_all();
    cfg_write(8'h59, 8'h03);  // index 0: reserved
    access("R4 reserved field no window", 1'b0, 32'h000F_0000, 1'b0);
    clear_all();
  endtask

  task automatic t_shadow();
    set_field(5, 4'h2);
    access("R7 write-only write to DRAM", 1'b1, 32'h000C_C010, 1'b1);
    access("R6 write-only read to bus", 1'b0, 32'h000C_C010, 1'b0);
    set_field(5, 4'h3);
    access("R6 both enables read DRAM", 1'b0, 32'h000C_C010, 1'b1);
    access("R7 both enables write DRAM", 1'b1, 32'h000C_C010, 1'b1);
    set_field(5, 4'h0);
    access("R6 cleared read bus", 1'b0, 32'h000C_C010, 1'b0);
    access("R7 cleared write bus", 1'b1, 32'h000C_C010, 1'b0);
  endtask

  task automatic t_spare();
    set_field(8, 4'hC);
    access("R9 spare bits read", 1'b0, win_lo(8), 1'b0);
    access("R9 spare bits write", 1'b1, win_lo(8), 1'b0);
    set_field(8, 4'hD);
    access("R9 spare plus RE read", 1'b0, win_lo(8), 1'b1);
    access("R9 spare plus RE write", 1'b1, win_lo(8), 1'b0);
    cfg_read("R2 spare bits stored", 8'h5D, 8'h0D);
    clear_all();
  endtask

  task automatic t_outside();
    access("R8 addr 0", 1'b0, 32'h0000_0000, 1'b1);
    access("R8 just below hole", 1'b1, 32'h000B_FFFF, 1'b1);
    access("R8 just above hole", 1'b0, 32'h0010_0000, 1'b1);
    access("R8 high alias", 1'b1, 32'hFFFF_0000, 1'b1);
    cfg_write(8'h5A, 8'h00);
  endtask

  task automatic t_timing();
    // window 4 = 0xC8000, field in byte 0x5B low nibble
    @(negedge clk);
    cfg_wr = 1'b1; cfg_off = 8'h5B; cfg_wdata = 8'h01;
    mem_valid = 1'b1; mem_write = 1'b0; mem_addr = 32'h000C_8000;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R10 same-cycle access uses old value", {30'h0, dram_sel, bus_fwd}, 32'h1);
    @(negedge clk);
    mem_valid = 1'b0;
    check("R10 next-cycle access uses new value", {30'h0, dram_sel, bus_fwd}, 32'h2);
    @(negedge clk);
    check("R11 idle after access", {29'h0, acc_valid, dram_sel, bus_fwd}, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_map();
    t_shadow();
    t_spare();
    t_outside();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule